// File: doc/BRIEF.md
# Bus Trigger Unit

This unit watches the instruction-fetch bus and the data bus of a processor and raises debug actions when programmed conditions are met. Each trigger slot holds an address value, a data value and a control word. A slot is tied to one bus. On the instruction bus it compares the fetch address. On the data bus it can compare the address, the data value and the cycle kind (read or write), and it requires every condition it has enabled at the same time. Two neighbouring slots can be joined into one range condition: the even slot holds the lower bound and the odd slot holds the upper bound.

A match produces a set of action pulses: break, external trigger, trace start, trace stop, trace sample and arm. Any slot can arm the unit. Other slots can be told to fire only once the unit is armed, so event B can only follow event A. The armed state stays set until the host writes any configuration register. A host debugger loads the slots through a simple write-only register port.

Top module: `dbt_trigger_unit`

## Requirements
- R1: An instruction-bus slot (control bit 1 = 0) with address compare enabled (bit 2) matches a cycle that has `ivalid_i` high and `iaddr_i` equal to the slot's address value. Data-bus activity never matches it.
- R2: A data-bus slot (bit 1 = 1) matches only on cycles where `drd_i` or `dwr_i` is high. All of its enabled conditions must hold together: address equality (bit 2), data equality (bit 3), and cycle kind. For cycle kind, bit 4 accepts reads, bit 5 accepts writes, and with neither set any kind is accepted.
- R3: Range mode (bit 6) is honoured only on an even slot that has an odd neighbour. The compared address and data are then accepted when they lie between the even slot's values and the odd slot's values, both bounds included. The odd slot's own matching is suppressed while it is paired.
- R4: The action bits of the control word are bit 8 break, 9 external trigger, 10 trace on, 11 trace off, 12 trace sample and 13 arm. Each action appears as a one-cycle pulse in the clock cycle after the matching bus cycle. A cycle with no bus activity gives no pulse in the next cycle. Actions of slots that match together are ORed.
- R5: The trace-sample action is dropped for instruction-bus slots.
- R6: A slot with bit 7 set fires only if the unit was armed before the current cycle. An arm action in the same cycle does not release it.
- R7: Once armed, the unit stays armed until the host writes any register. That write disarms the unit, and it wins over an arm action in the same cycle.
- R8: A slot with bit 0 clear never fires. Reset clears every slot's configuration, the armed state and all outputs.
- R9: Register address `cfg_addr_i` is {slot index, select}. The select field, in the two low bits, chooses the register: 0 = address value, 1 = data value, 2 = control word, 3 = no register written (the write still disarms).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ivalid_i | input | 1 | Instruction fetch cycle valid |
| iaddr_i | input | AW | Instruction fetch address |
| drd_i | input | 1 | Data bus read strobe |
| dwr_i | input | 1 | Data bus write strobe |
| daddr_i | input | AW | Data bus address |
| ddata_i | input | DW | Data bus value |
| cfg_we_i | input | 1 | Host register write strobe |
| cfg_addr_i | input | IW+2 | Host register address {slot, select} |
| cfg_wdata_i | input | DW | Host write data |
| brk_o | output | 1 | Break action pulse |
| ext_trig_o | output | 1 | External trigger pulse |
| trace_on_o | output | 1 | Trace start pulse |
| trace_off_o | output | 1 | Trace stop pulse |
| trace_smp_o | output | 1 | Trace sample pulse |
| arm_o | output | 1 | Arm action pulse |

## Verification
A corrupted comparator setting or a wrong range pairing shows up as a missing or extra action pulse exactly one cycle after the bus cycle that should have matched. A mis-held armed latch is hidden until the next cycle that matches an arm-gated slot. At that cycle a pulse appears or disappears on that slot's action output. The bench therefore follows every arm, disarm and same-cycle conflict with a probe cycle on a gated slot. This exposes the latch state through the pulse outputs one cycle later.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  // control word, packed MSB first: act[13:8] need_arm[7] rng[6] use_wr[5]
  // use_rd[4] use_data[3] use_addr[2] bus[1] en[0]
  typedef struct packed {
    logic [5:0] act;
    logic       need_arm;
    logic       rng;
    logic       use_wr;
    logic       use_rd;
    logic       use_data;
    logic       use_addr;
    logic       bus;
    logic       en;
  } trig_ctrl_t;

  localparam int CTRL_W = $bits(trig_ctrl_t);
  localparam int NACT   = 6;

  localparam int A_BRK  = 0;
  localparam int A_EXT  = 1;
  localparam int A_TON  = 2;
  localparam int A_TOFF = 3;
  localparam int A_TSMP = 4;
  localparam int A_ARM  = 5;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/dbt_regs.sv
module dbt_regs
  import dbt_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IW+1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [AW-1:0]    addr_val [NTRIG],
  output logic [DW-1:0]    data_val [NTRIG],
  output trig_ctrl_t       ctrl     [NTRIG]
);
  logic [IW-1:0] slot;
  logic [1:0]    sel;
  trig_ctrl_t    wr_ctrl;

  assign slot    = cfg_addr[IW+1:2];
  assign sel     = cfg_addr[1:0];
  assign wr_ctrl = trig_ctrl_t'(cfg_wdata[CTRL_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTRIG; i++) begin
        addr_val[i] <= '0;
        data_val[i] <= '0;
        ctrl[i]     <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NTRIG; i++) begin
        if (slot == IW'(i)) begin
          case (sel)
            SEL_ADDR: addr_val[i] <= cfg_wdata[AW-1:0];
            SEL_DATA: data_val[i] <= cfg_wdata;
            SEL_CTRL: begin
              ctrl[i] <= wr_ctrl;
              // pairing only from an even slot that has an odd neighbour
              if ((i % 2) != 0 || (i + 1) >= NTRIG) ctrl[i].rng <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dbt_match.sv
module dbt_match
  import dbt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  trig_ctrl_t       ctrl,
  input  logic [AW-1:0]    lo_addr,
  input  logic [AW-1:0]    hi_addr,
  input  logic [DW-1:0]    lo_data,
  input  logic [DW-1:0]    hi_data,
  input  logic             suppress,
  input  logic             armed,
  input  logic             ivalid,
  input  logic [AW-1:0]    iaddr,
  input  logic             drd,
  input  logic             dwr,
  input  logic [AW-1:0]    daddr,
  input  logic [DW-1:0]    ddata,
  output logic [NACT-1:0]  act_req
);
  logic [AW-1:0] addr_x;
  logic          cyc, addr_ok, data_ok, kind_ok, hit;
  logic [NACT-1:0] act_mask;

  always_comb begin
    addr_x = ctrl.bus ? daddr : iaddr;
    cyc    = ctrl.bus ? (drd | dwr) : ivalid;

    if (!ctrl.use_addr)      addr_ok = 1'b1;
    else if (ctrl.rng)       addr_ok = (addr_x >= lo_addr) && (addr_x <= hi_addr);
    else                     addr_ok = (addr_x == lo_addr);

    if (!ctrl.bus || !ctrl.use_data) data_ok = 1'b1;
    else if (ctrl.rng)       data_ok = (ddata >= lo_data) && (ddata <= hi_data);
    else                     data_ok = (ddata == lo_data);

    if (!ctrl.bus || !(ctrl.use_rd || ctrl.use_wr)) kind_ok = 1'b1;
    else kind_ok = (ctrl.use_rd && drd) || (ctrl.use_wr && dwr);

    hit = ctrl.en && !suppress && cyc && addr_ok && data_ok && kind_ok &&
          (!ctrl.need_arm || armed);

    act_mask = '1;
    if (!ctrl.bus) act_mask[A_TSMP] = 1'b0;

    act_req = hit ? (ctrl.act & act_mask) : '0;
  end
endmodule

// File: rtl/dbt_actions.sv
module dbt_actions
  import dbt_pkg::*;
#(
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [NACT-1:0]  act_req [NTRIG],
  output logic [NACT-1:0]  act_q,
  output logic             armed_q
);
  logic [NACT-1:0] act_any;

  always_comb begin
    act_any = '0;
    for (int i = 0; i < NTRIG; i++) act_any = act_any | act_req[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      act_q <= act_any;
      if (cfg_we)              armed_q <= 1'b0;
      else if (act_any[A_ARM]) armed_q <= 1'b1;
    end
  end

  // R6: the latch only sets after an arm action seen in the cycle before
  p_arm_set_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> ($past(act_any[A_ARM]) && !$past(cfg_we)));

  // R7: a host write always leaves the unit disarmed
  p_host_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we) |-> !armed_q);

  // R7: without a host write the latch never drops
  p_armed_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(armed_q) && !$past(cfg_we)) |-> armed_q);
endmodule

// File: rtl/dbt_trigger_unit.sv
module dbt_trigger_unit
  import dbt_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ivalid_i,
  input  logic [AW-1:0]    iaddr_i,
  input  logic             drd_i,
  input  logic             dwr_i,
  input  logic [AW-1:0]    daddr_i,
  input  logic [DW-1:0]    ddata_i,
  input  logic             cfg_we_i,
  input  logic [IW+1:0]    cfg_addr_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic             brk_o,
  output logic             ext_trig_o,
  output logic             trace_on_o,
  output logic             trace_off_o,
  output logic             trace_smp_o,
  output logic             arm_o
);
  logic [AW-1:0]   addr_val [NTRIG];
  logic [DW-1:0]   data_val [NTRIG];
  trig_ctrl_t      ctrl     [NTRIG];
  logic [NACT-1:0] act_req  [NTRIG];
  logic [NACT-1:0] act_q;
  logic            armed_q;

  dbt_regs #(.NTRIG(NTRIG), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we_i),
    .cfg_addr  (cfg_addr_i),
    .cfg_wdata (cfg_wdata_i),
    .addr_val  (addr_val),
    .data_val  (data_val),
    .ctrl      (ctrl)
  );

  for (genvar i = 0; i < NTRIG; i++) begin : g_slot
    logic [AW-1:0] hi_a;
    logic [DW-1:0] hi_d;
    logic          supp;

    if ((i % 2) == 0 && (i + 1) < NTRIG) begin : g_lead
      assign hi_a = addr_val[i+1];
      assign hi_d = data_val[i+1];
      assign supp = 1'b0;
    end else if ((i % 2) == 1) begin : g_tail
      assign hi_a = addr_val[i];
      assign hi_d = data_val[i];
      assign supp = ctrl[i-1].rng;
    end else begin : g_lone
      assign hi_a = addr_val[i];
      assign hi_d = data_val[i];
      assign supp = 1'b0;
    end

    dbt_match #(.AW(AW), .DW(DW)) u_match (
      .ctrl     (ctrl[i]),
      .lo_addr  (addr_val[i]),
      .hi_addr  (hi_a),
      .lo_data  (data_val[i]),
      .hi_data  (hi_d),
      .suppress (supp),
      .armed    (armed_q),
      .ivalid   (ivalid_i),
      .iaddr    (iaddr_i),
      .drd      (drd_i),
      .dwr      (dwr_i),
      .daddr    (daddr_i),
      .ddata    (ddata_i),
      .act_req  (act_req[i])
    );
  end

  dbt_actions #(.NTRIG(NTRIG)) u_act (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we_i),
    .act_req (act_req),
    .act_q   (act_q),
    .armed_q (armed_q)
  );

  assign brk_o       = act_q[A_BRK];
  assign ext_trig_o  = act_q[A_EXT];
  assign trace_on_o  = act_q[A_TON];
  assign trace_off_o = act_q[A_TOFF];
  assign trace_smp_o = act_q[A_TSMP];
  assign arm_o       = act_q[A_ARM];

  // R4: no bus activity in a cycle means no action pulse in the next one
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(ivalid_i || drd_i || dwr_i) |->
      !(brk_o || ext_trig_o || trace_on_o || trace_off_o || trace_smp_o || arm_o));

  // R5: a sample pulse must come from a data-bus cycle
  p_smp_data_only_r5: assert property (@(posedge clk) disable iff (rst)
    trace_smp_o |-> $past(drd_i || dwr_i));
endmodule

// File: tb/dbt_trigger_unit_tb.sv
`timescale 1ns/1ps
module dbt_trigger_unit_tb;
  localparam int NTRIG = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ivalid = 1'b0, drd = 1'b0, dwr = 1'b0;
  logic [AW-1:0] iaddr = '0, daddr = '0;
  logic [DW-1:0] ddata = '0;
  logic cfg_we = 1'b0;
  logic [IW+1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic brk, ext, ton, toff, tsmp, arm;
  logic [5:0] outs;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dbt_trigger_unit #(.NTRIG(NTRIG), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .ivalid_i(ivalid), .iaddr_i(iaddr),
    .drd_i(drd), .dwr_i(dwr), .daddr_i(daddr), .ddata_i(ddata),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .brk_o(brk), .ext_trig_o(ext), .trace_on_o(ton), .trace_off_o(toff),
    .trace_smp_o(tsmp), .arm_o(arm)
  );

  // output order {arm, smp, off, on, ext, brk}
  assign outs = {arm, tsmp, toff, ton, ext, brk};

  typedef struct packed {
    logic        iv;
    logic [31:0] ia;
    logic        rd;
    logic        wr;
    logic [31:0] da;
    logic [31:0] dd;
    logic [5:0]  exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    32'h0,  6'b000000}, // idle
    '{1'b1, 32'h100,  1'b0, 1'b0, 32'h0,    32'h0,  6'b000001}, // R1 hit, R5 smp dropped
    '{1'b1, 32'h104,  1'b0, 1'b0, 32'h0,    32'h0,  6'b000000}, // R1 miss
    '{1'b0, 32'h0,    1'b0, 1'b1, 32'h2000, 32'h5,  6'b010010}, // R2 write to addr
    '{1'b0, 32'h0,    1'b1, 1'b0, 32'h2000, 32'h0,  6'b000000}, // R2 read rejected
    '{1'b0, 32'h0,    1'b1, 1'b0, 32'h40,   32'h10, 6'b000100}, // R3 low bound
    '{1'b0, 32'h0,    1'b1, 1'b0, 32'h40,   32'h20, 6'b000100}, // R3 high bound, partner muted
    '{1'b0, 32'h0,    1'b1, 1'b0, 32'h40,   32'h21, 6'b000000}, // R3 above
    '{1'b0, 32'h0,    1'b1, 1'b0, 32'h40,   32'h0F, 6'b000000}, // R3 below
    '{1'b1, 32'h100,  1'b0, 1'b1, 32'h2000, 32'h18, 6'b010111}, // R4 OR of slots
    '{1'b0, 32'h0,    1'b0, 1'b1, 32'h2004, 32'h0,  6'b000000}, // R2 addr miss
    '{1'b1, 32'h2000, 1'b0, 1'b0, 32'h0,    32'h0,  6'b000000}  // R2 data slot ignores fetch
  };

  function automatic logic [31:0] mk(input logic en, input logic bus,
      input logic ua, input logic ud, input logic urd, input logic uwr,
      input logic rng, input logic narm, input logic [5:0] act);
    return {18'b0, act, narm, rng, uwr, urd, ud, ua, bus, en};
  endfunction

  task automatic check(input logic [5:0] exp, input string tag);
    checks++;
    if (outs !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, outs, exp);
    end
  endtask

  task automatic idle();
    ivalid = 1'b0; drd = 1'b0; dwr = 1'b0;
    iaddr = '0; daddr = '0; ddata = '0;
  endtask

  task automatic wr_cfg(input int slot, input int sel, input logic [31:0] v);
    cfg_we = 1'b1;
    cfg_addr = {IW'(slot), 2'(sel)};
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input logic iv, input logic [31:0] ia, input logic rd,
      input logic wr, input logic [31:0] da, input logic [31:0] dd,
      input logic [5:0] exp, input string tag);
    ivalid = iv; iaddr = ia; drd = rd; dwr = wr; daddr = da; ddata = dd;
    @(negedge clk);
    check(exp, tag);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(6'b0, "R8 outputs during reset");
    rst = 1'b0;
    @(negedge clk);
    check(6'b0, "R8 outputs after reset");

    // R9 map: sel 0 addr, 1 data, 2 ctrl
    wr_cfg(0, 0, 32'h100);
    wr_cfg(0, 2, mk(1,0,1,0,0,0,0,0, 6'b010001));
    wr_cfg(1, 0, 32'h2000);
    wr_cfg(1, 2, mk(1,1,1,0,0,1,0,0, 6'b010010));
    wr_cfg(2, 1, 32'h10);
    wr_cfg(2, 2, mk(1,1,0,1,0,0,1,0, 6'b000100));
    wr_cfg(3, 1, 32'h20);
    wr_cfg(3, 2, mk(1,1,0,1,0,0,0,0, 6'b001000));

    for (int v = 0; v < NV; v++) begin
      step(VEC[v].iv, VEC[v].ia, VEC[v].rd, VEC[v].wr, VEC[v].da, VEC[v].dd,
           VEC[v].exp, $sformatf("vec %0d (R1 R2 R3 R4 R5 R9)", v));
    end

    // R3 address range on the pair, inclusive bounds
    wr_cfg(2, 0, 32'h1000);
    wr_cfg(3, 0, 32'h10FF);
    wr_cfg(2, 2, mk(1,1,1,0,0,0,1,0, 6'b000100));
    step(0,0,1,0, 32'h10FF, 0, 6'b000100, "R3 addr upper bound");
    step(0,0,1,0, 32'h1000, 0, 6'b000100, "R3 addr lower bound");
    step(0,0,1,0, 32'h1100, 0, 6'b000000, "R3 addr above");
    step(0,0,1,0, 32'h0FFF, 0, 6'b000000, "R3 addr below");

    // arming: slot 0 arms on fetch 0x300, slot 1 gated write to 0x2000
    wr_cfg(2, 2, 32'h0);
    wr_cfg(3, 2, 32'h0);
    wr_cfg(0, 0, 32'h300);
    wr_cfg(0, 2, mk(1,0,1,0,0,0,0,0, 6'b100000));
    wr_cfg(1, 2, mk(1,1,1,0,0,1,0,1, 6'b000010));
    step(0,0,0,1, 32'h2000, 0, 6'b000000, "R6 gated slot before arm");
    step(1,32'h300,0,1, 32'h2000, 0, 6'b100000, "R6 same-cycle arm does not release");
    step(0,0,0,1, 32'h2000, 0, 6'b000010, "R6 gated slot after arm");
    step(0,0,0,1, 32'h2000, 0, 6'b000010, "R7 armed stays latched");
    @(negedge clk);
    step(0,0,0,1, 32'h2000, 0, 6'b000010, "R7 armed after idle cycle");
    wr_cfg(0, 3, 32'hFFFF_FFFF);
    step(0,0,0,1, 32'h2000, 0, 6'b000000, "R7 host write disarms");
    step(1,32'h300,0,0, 0, 0, 6'b100000, "R9 select 3 left slot 0 intact");
    // re-armed by the step above; clear and arm in the same cycle
    cfg_we = 1'b1; cfg_addr = {2'd0, 2'd3}; cfg_wdata = '0;
    ivalid = 1'b1; iaddr = 32'h300;
    @(negedge clk);
    check(6'b100000, "R7 arm pulse during host write");
    cfg_we = 1'b0;
    idle();
    step(0,0,0,1, 32'h2000, 0, 6'b000000, "R7 host write wins over arm");

    // R8 disabled slot
    wr_cfg(0, 2, mk(0,0,1,0,0,0,0,0, 6'b000001));
    step(1,32'h300,0,0, 0, 0, 6'b000000, "R8 disabled slot silent");

    // R8 reset wipes configuration
    wr_cfg(0, 2, mk(1,0,1,0,0,0,0,0, 6'b000001));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step(1,32'h300,0,0, 0, 0, 6'b000000, "R8 config cleared by reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule